// File: doc/BRIEF.md
# Dual-Channel Sample Pattern Substitution Unit

This unit sits between two converter sample streams (channel A and channel B) and the output formatter. On every clock it looks at a per-channel 3-bit mode field and either forwards the live sample of that channel or replaces it with a synthetic word. The synthetic word is either a fixed value or a ramp that steps on every valid sample. One shared 18-bit pattern value serves both purposes: it is the fixed word in constant mode and the step size in ramp mode. Patterns are produced at the full native width with the MSB aligned, ahead of any bit remapping, so they look the same whatever output format follows.

The pattern value and both mode fields arrive as three 8-bit configuration bytes. The low byte holds pattern bits [7:0] and the middle byte holds bits [15:8]. The high byte carries pattern bits [17:16] in its bits [1:0], the channel A mode in bits [4:2] and the channel B mode in bits [7:5]. Each channel runs a small state machine with three states: LIVE (forward samples), RAMP (emit the accumulator) and FIXED (emit the pattern). Transitions happen every clock and follow the decoded mode field. Any state goes to RAMP on code 010 and to FIXED on code 011. Every other code sends the channel to LIVE. Moving into RAMP from another state clears that channel's ramp accumulator.

To get a ramp that steps by one LSB at a reduced output resolution, software sets the step to 0x00001 for 18 bits, 0x00004 for 16 bits or 0x00010 for 14 bits.

Top module: `tpat_gen`

## Requirements
- R1: While reset is asserted and right after it, out_vld is 0 and out_a and out_b are 0.
- R2: out_vld equals smp_vld from the previous clock (one register stage of latency).
- R3: For mode code 000 on a channel, a valid sample appears unchanged on that channel's output one clock later.
- R4: For mode code 011, a valid sample is replaced by the 18-bit pattern {cfg_pat_hi[1:0], cfg_pat_mid, cfg_pat_lo}.
- R5: For mode code 010, each valid sample is replaced by the ramp accumulator, and the accumulator then advances by the 18-bit pattern value. Cycles without a valid sample leave it unchanged.
- R6: The ramp accumulator is 18 bits wide and wraps modulo 2^18.
- R7: Mode codes 001, 100, 101, 110 and 111 behave like 000: live data passes through.
- R8: The channel A mode is taken from cfg_pat_hi[4:2] and the channel B mode from cfg_pat_hi[7:5]. Each channel acts on its own field only.
- R9: The first valid sample after a channel enters code 010 from any other code yields 0, both after reset and on re-entry.
- R10: In a cycle without a valid sample, out_a and out_b keep their previous values at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample-valid strobe for both channels |
| smp_a | input | 18 | Live sample, channel A |
| smp_b | input | 18 | Live sample, channel B |
| cfg_pat_lo | input | 8 | Pattern bits [7:0] |
| cfg_pat_mid | input | 8 | Pattern bits [15:8] |
| cfg_pat_hi | input | 8 | [1:0] pattern bits [17:16], [4:2] mode A, [7:5] mode B |
| out_a | output | 18 | Output word, channel A |
| out_b | output | 18 | Output word, channel B |
| out_vld | output | 1 | Output valid, smp_vld delayed by one clock |

## Verification
The bench builds the unit with its default 18-bit sample width. At that width all three configuration bytes are fully used, and a step of 0x20000 or 0x3FFFF reaches the wrap of the 18-bit accumulator within a few samples. Random mode changes on both channels, including the unused codes, cause frequent entries into and exits from ramp mode with valid gaps in between. The restart-at-zero rule and the hold-on-invalid rule are therefore exercised many times, independently on each channel.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MC_LIVE  = 3'b000,
        MC_RAMP  = 3'b010,
        MC_FIXED = 3'b011
    } mode_code_e;

    typedef enum logic [1:0] {
        ST_LIVE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_FIXED = 2'd2
    } lane_st_e;

endpackage

// File: rtl/tpat_cfg_unpack.sv
module tpat_cfg_unpack
    import tpat_pkg::*;
#(
    parameter int DW = 18,
    parameter int RW = 8,
    parameter int NCH = 2
) (
    input  logic [RW-1:0]        lo_byte,
    input  logic [RW-1:0]        mid_byte,
    input  logic [RW-1:0]        hi_byte,
    output logic [DW-1:0]        pattern,
    output logic [NCH*MODE_W-1:0] modes
);
    localparam int HI_PAT_W = DW - 2*RW;

    assign pattern = {hi_byte[HI_PAT_W-1:0], mid_byte, lo_byte};

    for (genvar c = 0; c < NCH; c++) begin : g_mode
        assign modes[c*MODE_W +: MODE_W] = hi_byte[HI_PAT_W + c*MODE_W +: MODE_W];
    end
endmodule

// File: rtl/tpat_lane.sv
module tpat_lane
    import tpat_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     live,
    input  logic [DW-1:0]     pat,
    output logic [DW-1:0]     dout
);
    lane_st_e      cur_st;
    lane_st_e      nxt_st;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] ramp_base;
    logic [DW-1:0] word;

    // next state: every state follows the mode field each clock
    always_comb begin
        unique case (mode)
            MC_RAMP:  nxt_st = ST_RAMP;
            MC_FIXED: nxt_st = ST_FIXED;
            default:  nxt_st = ST_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= ST_LIVE;
        else        cur_st <= nxt_st;
    end

    // entering RAMP from another state restarts the ramp at zero
    assign ramp_base = (cur_st != ST_RAMP) ? '0 : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (nxt_st == ST_RAMP) begin
            acc_q <= vld ? (ramp_base + pat) : ramp_base;
        end
    end

    // output selection
    always_comb begin
        unique case (nxt_st)
            ST_RAMP:  word = ramp_base;
            ST_FIXED: word = pat;
            default:  word = live;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dout <= '0;
        else if (vld) dout <= word;
    end
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int DW = 18,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_a,
    input  logic [DW-1:0] smp_b,
    input  logic [RW-1:0] cfg_pat_lo,
    input  logic [RW-1:0] cfg_pat_mid,
    input  logic [RW-1:0] cfg_pat_hi,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          out_vld
);
    localparam int NCH = 2;

    logic [DW-1:0]         pattern;
    logic [NCH*MODE_W-1:0] modes;
    logic [DW-1:0]         live_arr [NCH];
    logic [DW-1:0]         dout_arr [NCH];

    tpat_cfg_unpack #(.DW(DW), .RW(RW), .NCH(NCH)) u_cfg (
        .lo_byte  (cfg_pat_lo),
        .mid_byte (cfg_pat_mid),
        .hi_byte  (cfg_pat_hi),
        .pattern  (pattern),
        .modes    (modes)
    );

    assign live_arr[0] = smp_a;
    assign live_arr[1] = smp_b;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        tpat_lane #(.DW(DW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (smp_vld),
            .mode  (modes[c*MODE_W +: MODE_W]),
            .live  (live_arr[c]),
            .pat   (pattern),
            .dout  (dout_arr[c])
        );
    end

    assign out_a = dout_arr[0];
    assign out_b = dout_arr[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= smp_vld;
    end
endmodule

// File: rtl/tpat_chk.sv
module tpat_chk #(
    parameter int DW = 18,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [DW-1:0] smp_a,
    input logic [DW-1:0] smp_b,
    input logic [RW-1:0] cfg_pat_lo,
    input logic [RW-1:0] cfg_pat_mid,
    input logic [RW-1:0] cfg_pat_hi,
    input logic [DW-1:0] out_a,
    input logic [DW-1:0] out_b,
    input logic          out_vld
);
    logic [2:0]    ma;
    logic [2:0]    mb;
    logic [DW-1:0] pat;
    assign ma  = cfg_pat_hi[4:2];
    assign mb  = cfg_pat_hi[7:5];
    assign pat = {cfg_pat_hi[1:0], cfg_pat_mid, cfg_pat_lo};

    a_r2_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_vld == $past(smp_vld));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(out_a) && $stable(out_b));

    a_r3_live_a: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && ma == 3'b000 |=> out_a == $past(smp_a));

    a_r4_fixed_b: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && mb == 3'b011 |=> out_b == $past(pat));

    a_r7_unused_b: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && mb != 3'b010 && mb != 3'b011 |=> out_b == $past(smp_b));

    a_r9_entry_a: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && ma == 3'b010 && $past(ma) != 3'b010 |=> out_a == '0);
endmodule

bind tpat_gen tpat_chk #(.DW(DW), .RW(RW)) u_chk (.*);

// File: tb/sim_tpat_gen.sv
module sim_tpat_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_a = '0;
    logic [DW-1:0] smp_b = '0;
    logic [7:0]    cfg_pat_lo = '0;
    logic [7:0]    cfg_pat_mid = '0;
    logic [7:0]    cfg_pat_hi = '0;
    logic [DW-1:0] out_a;
    logic [DW-1:0] out_b;
    logic          out_vld;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    logic [DW-1:0] m_acc_a, m_acc_b, e_a, e_b;
    bit            m_ramp_a, m_ramp_b, e_vld;
    string         tag_a, tag_b, tag_ovr;
    bit            pend = 0;

    tpat_gen u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_ramp(logic [2:0] m);
        return m == 3'b010;
    endfunction

    function automatic string mode_tag(logic [2:0] m, bit entry);
        if (m == 3'b000) return "R3";
        if (m == 3'b011) return "R4";
        if (m == 3'b010) return entry ? "R9" : "R5";
        return "R7";
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    task automatic check_out();
        check("R2", {17'd0, out_vld}, {17'd0, e_vld});
        check(tag_a, out_a, e_a);
        check(tag_b, out_b, e_b);
    endtask

    task automatic model_reset();
        m_acc_a = '0; m_acc_b = '0; m_ramp_a = 0; m_ramp_b = 0;
        e_a = '0; e_b = '0; e_vld = 0; tag_a = "R1"; tag_b = "R1";
    endtask

    // one clock: check the previous result, then drive new inputs
    task automatic step(bit v, logic [DW-1:0] a, logic [DW-1:0] b,
                        logic [2:0] ma, logic [2:0] mb, logic [DW-1:0] pat);
        logic [DW-1:0] w;
        bit ent;
        @(negedge clk);
        if (pend) check_out();
        smp_vld = v; smp_a = a; smp_b = b;
        cfg_pat_lo = pat[7:0]; cfg_pat_mid = pat[15:8];
        cfg_pat_hi = {mb, ma, pat[17:16]};
        e_vld = v;
        // channel A
        ent = is_ramp(ma) && !m_ramp_a;
        if (ent) m_acc_a = '0;
        if (v) begin
            w = is_ramp(ma) ? m_acc_a : (ma == 3'b011) ? pat : a;
            e_a = w;
            tag_a = (tag_ovr != "") ? tag_ovr : mode_tag(ma, ent);
            if (is_ramp(ma)) m_acc_a = m_acc_a + pat;
        end else tag_a = "R10";
        m_ramp_a = is_ramp(ma);
        // channel B
        ent = is_ramp(mb) && !m_ramp_b;
        if (ent) m_acc_b = '0;
        if (v) begin
            w = is_ramp(mb) ? m_acc_b : (mb == 3'b011) ? pat : b;
            e_b = w;
            tag_b = (tag_ovr != "") ? tag_ovr : mode_tag(mb, ent);
            if (is_ramp(mb)) m_acc_b = m_acc_b + pat;
        end else tag_b = "R10";
        m_ramp_b = is_ramp(mb);
        pend = 1;
    endtask

    initial begin
        logic [2:0] ma, mb;
        logic [DW-1:0] pat;
        void'($urandom(32'd4242));
        tag_ovr = "";
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", out_a, '0);
        check("R1", out_b, '0);
        check("R1", {17'd0, out_vld}, '0);
        rst_n = 1'b1;
        // R1: first clock after reset with no valid input
        step(0, 18'h3FFFF, 18'h3FFFF, 3'b011, 3'b011, 18'h2AAAA);
        // R8: A fixed, B ramp with a one-LSB step at 16 bits
        tag_ovr = "R8";
        for (int i = 0; i < 4; i++) step(1, 18'h11111, 18'h22222, 3'b011, 3'b010, 18'h00004);
        tag_ovr = "";
        // R5: gaps in valid keep the ramp
        for (int i = 0; i < 6; i++) step(i[0], 18'h0, 18'h0, 3'b010, 3'b010, 18'h00010);
        // R9: leave and re-enter ramp
        step(1, 18'h01234, 18'h04321, 3'b000, 3'b101, 18'h00010);
        for (int i = 0; i < 3; i++) step(1, 18'h0, 18'h0, 3'b010, 3'b010, 18'h00001);
        // R6: wrap modulo 2^18
        step(1, 18'h0, 18'h0, 3'b000, 3'b000, 18'h20000);
        tag_ovr = "R6";
        for (int i = 0; i < 4; i++) step(1, 18'h0, 18'h0, 3'b010, 3'b010, 18'h20000);
        for (int i = 0; i < 3; i++) step(1, 18'h0, 18'h0, 3'b010, 3'b010, 18'h3FFFF);
        tag_ovr = "";
        // R4: all-ones fixed word
        step(1, 18'h0, 18'h0, 3'b011, 3'b011, 18'h3FFFF);
        // random phase
        ma = 3'b000; mb = 3'b000; pat = 18'h00001;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                ma = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(2, 3));
                mb = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(2, 3));
                pat = 18'($urandom);
            end
            step($urandom_range(0, 3) != 0, 18'($urandom), 18'($urandom), ma, mb, pat);
        end
        @(negedge clk);
        check_out();
        // R1: reset in the middle of activity
        rst_n = 1'b0;
        pend = 0;
        model_reset();
        @(negedge clk);
        check("R1", out_a, '0);
        check("R1", out_b, '0);
        check("R1", {17'd0, out_vld}, '0);
        rst_n = 1'b1;
        step(1, 18'h0, 18'h0, 3'b010, 3'b010, 18'h00007);
        step(1, 18'h0, 18'h0, 3'b010, 3'b010, 18'h00007);
        @(negedge clk);
        check_out();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule